// File: doc/BRIEF.md
# Tone Detection Steering Guard Logic

This block is the digital qualification stage that follows a tone-pair detector. It receives a raw "valid pair present" flag together with the 4-bit code the detector decoded. It turns them into four outputs: an immediate early indication, a time-qualified steering state, a held output code, and a one-clock strobe that marks each new digit. Programmable counters replace an external resistor-capacitor network. They set how long a tone must persist before it is accepted and how long it must be absent before the block re-arms.

Two levels of steering are used. The early flag mirrors the detector with no delay. The steering state moves only after the early flag has disagreed with it for the programmed number of clock edges. A guard output marks those cycles of disagreement, and the timer runs only while it is high. The code register loads, and the strobe fires, only on a low-to-high transition of the steering state. A tone that is held therefore yields exactly one digit, and short dropouts inside a digit are absorbed.

Top module: `tone_steer_guard`

## Requirements
- R1: While `rst_n` is low, and on the cycles that follow its release while `pair_valid_i` stays low, `steer_o`, `digit_stb_o` and `guard_o` are 0 and `code_o` is 4'h0.
- R2: `early_o` equals `pair_valid_i` in the same cycle, with no register delay, whether the input rises or falls.
- R3: From a settled idle state, `steer_o` rises after `pair_valid_i` has been sampled high on N consecutive rising clock edges, where N is `present_lim_i`; a value of 0 acts as 1.
- R4: A single low sample of `pair_valid_i` before the tone-present count completes restarts that count from zero.
- R5: When `steer_o` is high, it falls only after `pair_valid_i` has been sampled low on M consecutive edges, where M is `absent_lim_i` (0 acts as 1). A shorter dropout leaves `steer_o` high and produces no strobe.
- R6: On the edge where `steer_o` rises, `code_o` takes the value on `pair_code_i` at that edge. At all other times it holds, even if `pair_code_i` changes while the tone is held.
- R7: `digit_stb_o` is high for exactly one cycle, and that cycle is the first cycle in which `steer_o` reads high.
- R8: A tone held for any length produces a single strobe. A further digit is strobed only after `steer_o` has fallen and risen again.
- R9: `guard_o` is high exactly when `early_o` and `steer_o` differ, and `steer_o` changes only after a cycle in which `guard_o` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pair_valid_i | input | 1 | Detector reports a valid tone pair |
| pair_code_i | input | 4 | Decoded code of the detected pair |
| present_lim_i | input | CNT_W | Edges of continuous presence needed to accept a tone |
| absent_lim_i | input | CNT_W | Edges of continuous absence needed to release a tone |
| early_o | output | 1 | Early steering flag, follows the detector at once |
| steer_o | output | 1 | Guard-qualified steering state |
| guard_o | output | 1 | Guard timing active (early and steering disagree) |
| code_o | output | 4 | Latched output code |
| digit_stb_o | output | 1 | One-cycle new-digit strobe |

## Verification
The steering function is driven with several patterns. A clean tone held past its threshold shows that acceptance happens on the exact edge, and that a held tone yields exactly one strobe. A tone broken one edge short of the threshold separates a restarting counter from a pausing one. A dropout one edge shorter than the absence limit, followed by a full-length release, shows that short gaps are ignored and that the fall happens on the exact edge. A second digit after release, a code change during a held tone, and a zero limit confirm re-arming, code holding and the zero boundary.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] code_t;
  typedef enum logic {ST_IDLE = 1'b0, ST_HELD = 1'b1} steer_e;
endpackage

// File: rtl/tsg_rst_sync.sv
module tsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tsg_guard_timer.sv
module tsg_guard_timer
  import tsg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             early,
  input  logic [CNT_W-1:0] present_lim,
  input  logic [CNT_W-1:0] absent_lim,
  output logic             steer,
  output logic             steer_rise
);
  localparam int EXT_W = CNT_W + 1;

  steer_e            st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  lim_sel;
  logic [EXT_W-1:0]  lim_eff;
  logic [EXT_W-1:0]  cnt_inc;
  logic              timing;
  logic              cnt_en;

  // Timing runs while the early flag disagrees with the steering state.
  assign timing  = early != (st_q == ST_HELD);
  assign lim_sel = (st_q == ST_HELD) ? absent_lim : present_lim;
  assign lim_eff = (lim_sel == '0) ? EXT_W'(1) : {1'b0, lim_sel};
  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);

  always_comb begin
    st_d  = st_q;
    cnt_d = '0;
    if (timing) begin
      if (cnt_inc >= lim_eff) begin
        st_d  = (st_q == ST_HELD) ? ST_IDLE : ST_HELD;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  // Counter only toggles while timing or while clearing a leftover count.
  assign cnt_en = timing || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign steer      = (st_q == ST_HELD);
  assign steer_rise = (st_d == ST_HELD) && (st_q == ST_IDLE);
endmodule

// File: rtl/tsg_code_latch.sv
module tsg_code_latch
  import tsg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  code_t code_in,
  output code_t code_out,
  output logic  strobe
);
  code_t code_q;
  logic  stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= load;
      if (load) code_q <= code_in;
    end
  end

  assign code_out = code_q;
  assign strobe   = stb_q;
endmodule

// File: rtl/tone_steer_guard.sv
module tone_steer_guard
  import tsg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_valid_i,
  input  logic [3:0]       pair_code_i,
  input  logic [CNT_W-1:0] present_lim_i,
  input  logic [CNT_W-1:0] absent_lim_i,
  output logic             early_o,
  output logic             steer_o,
  output logic             guard_o,
  output logic [3:0]       code_o,
  output logic             digit_stb_o
);
  logic  rst_int_n;
  logic  steer_w;
  logic  rise_w;
  code_t code_w;

  tsg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign early_o = pair_valid_i;

  tsg_guard_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .early       (early_o),
    .present_lim (present_lim_i),
    .absent_lim  (absent_lim_i),
    .steer       (steer_w),
    .steer_rise  (rise_w)
  );

  tsg_code_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (rise_w),
    .code_in  (pair_code_i),
    .code_out (code_w),
    .strobe   (digit_stb_o)
  );

  assign steer_o = steer_w;
  assign code_o  = code_w;
  assign guard_o = early_o ^ steer_w;
endmodule

// File: rtl/tsg_checker.sv
module tsg_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pair_valid_i,
  input logic [3:0]       pair_code_i,
  input logic [CNT_W-1:0] present_lim_i,
  input logic [CNT_W-1:0] absent_lim_i,
  input logic             early_o,
  input logic             steer_o,
  input logic             guard_o,
  input logic [3:0]       code_o,
  input logic             digit_stb_o
);
  always_comb begin
    assert_early_follow_R2: assert (early_o == pair_valid_i);
  end

  assert_rise_needs_tone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer_o) |-> $past(early_o));

  assert_fall_needs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steer_o) |-> !$past(early_o));

  assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !digit_stb_o |-> $stable(code_o));

  assert_stb_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    digit_stb_o |-> (steer_o && !$past(steer_o)));

  assert_stb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    digit_stb_o |=> !digit_stb_o);

  assert_move_after_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_o != $past(steer_o)) |-> $past(guard_o));
endmodule

bind tone_steer_guard tsg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pair_valid_i  (pair_valid_i),
  .pair_code_i   (pair_code_i),
  .present_lim_i (present_lim_i),
  .absent_lim_i  (absent_lim_i),
  .early_o       (early_o),
  .steer_o       (steer_o),
  .guard_o       (guard_o),
  .code_o        (code_o),
  .digit_stb_o   (digit_stb_o)
);

// File: tb/sim_tone_steer_guard.sv
`timescale 1ns/1ps
module sim_tone_steer_guard;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pair_valid_i;
  logic [3:0]       pair_code_i;
  logic [CNT_W-1:0] present_lim_i;
  logic [CNT_W-1:0] absent_lim_i;
  logic             early_o, steer_o, guard_o, digit_stb_o;
  logic [3:0]       code_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  tone_steer_guard #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pair_valid_i(pair_valid_i), .pair_code_i(pair_code_i),
    .present_lim_i(present_lim_i), .absent_lim_i(absent_lim_i),
    .early_o(early_o), .steer_o(steer_o), .guard_o(guard_o),
    .code_o(code_o), .digit_stb_o(digit_stb_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nxt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    pair_valid_i = 1'b0;
    nxt(absent_lim_i + 3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pair_valid_i = 1'b0; pair_code_i = 4'h0;
    present_lim_i = 8'd3; absent_lim_i = 8'd2;
    nxt(3);
    chk("R1 steer in reset", steer_o, 0);
    chk("R1 strobe in reset", digit_stb_o, 0);
    rst_n = 1'b1;
    nxt(4);
    chk("R1 steer after release", steer_o, 0);
    chk("R1 code after release", code_o, 0);
    chk("R1 guard after release", guard_o, 0);
    chk("R1 strobe after release", digit_stb_o, 0);
  endtask

  task automatic t_early();
    pair_valid_i = 1'b1;
    #1;
    chk("R2 early rises", early_o, 1);
    chk("R9 guard while timing", guard_o, 1);
    pair_valid_i = 1'b0;
    #1;
    chk("R2 early falls", early_o, 0);
    settle();
  endtask

  task automatic t_accept_hold();
    int stbs = 0;
    present_lim_i = 8'd3; absent_lim_i = 8'd2;
    pair_code_i = 4'h5; pair_valid_i = 1'b1;
    nxt(2);
    chk("R3 steer low before count", steer_o, 0);
    nxt(1);
    chk("R3 steer after 3 edges", steer_o, 1);
    chk("R7 strobe with rise", digit_stb_o, 1);
    chk("R6 code loaded", code_o, 5);
    chk("R9 guard clear when agreed", guard_o, 0);
    pair_code_i = 4'h9;
    for (int i = 0; i < 12; i++) begin
      nxt(1);
      stbs += digit_stb_o;
    end
    chk("R8 held tone no extra strobe", stbs, 0);
    chk("R6 code holds while held", code_o, 5);
    pair_valid_i = 1'b0;
    nxt(1);
    chk("R5 steer still high after 1 gap edge", steer_o, 1);
    nxt(1);
    chk("R5 steer falls after 2 gap edges", steer_o, 0);
    settle();
  endtask

  task automatic t_restart();
    present_lim_i = 8'd4;
    pair_code_i = 4'h2; pair_valid_i = 1'b1;
    nxt(3);
    pair_valid_i = 1'b0;
    nxt(1);
    pair_valid_i = 1'b1;
    nxt(3);
    chk("R4 count restarted after break", steer_o, 0);
    nxt(1);
    chk("R4 steer after full run", steer_o, 1);
    chk("R6 code after restart", code_o, 2);
    settle();
  endtask

  task automatic t_dropout();
    int stbs = 0;
    present_lim_i = 8'd2; absent_lim_i = 8'd3;
    pair_code_i = 4'hC; pair_valid_i = 1'b1;
    nxt(2);
    chk("R3 steer with limit 2", steer_o, 1);
    pair_valid_i = 1'b0;
    nxt(1); stbs += digit_stb_o;
    nxt(1); stbs += digit_stb_o;
    pair_valid_i = 1'b1;
    nxt(1); stbs += digit_stb_o;
    chk("R5 short dropout ignored", steer_o, 1);
    chk("R5 no strobe from dropout", stbs, 0);
    pair_valid_i = 1'b0;
    nxt(2);
    chk("R5 steer high before 3 gap edges", steer_o, 1);
    nxt(1);
    chk("R5 steer falls after 3 gap edges", steer_o, 0);
    settle();
  endtask

  task automatic t_second_digit();
    present_lim_i = 8'd2; absent_lim_i = 8'd2;
    pair_code_i = 4'h7; pair_valid_i = 1'b1;
    nxt(2);
    chk("R8 first digit strobe", digit_stb_o, 1);
    nxt(1);
    chk("R7 strobe lasts one cycle", digit_stb_o, 0);
    pair_valid_i = 1'b0;
    nxt(2);
    chk("R8 released", steer_o, 0);
    pair_code_i = 4'hA; pair_valid_i = 1'b1;
    nxt(2);
    chk("R8 second digit strobe", digit_stb_o, 1);
    chk("R6 second code", code_o, 10);
    settle();
  endtask

  task automatic t_zero_limit();
    present_lim_i = 8'd0; absent_lim_i = 8'd0;
    pair_code_i = 4'hF; pair_valid_i = 1'b1;
    nxt(1);
    chk("R3 zero limit acts as one", steer_o, 1);
    chk("R6 code with zero limit", code_o, 15);
    pair_valid_i = 1'b0;
    nxt(1);
    chk("R5 zero absent limit acts as one", steer_o, 0);
    settle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_early();
    t_accept_hold();
    t_restart();
    t_dropout();
    t_second_digit();
    t_zero_limit();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule